// File: doc/BRIEF.md
# Clock Output Power-Down Gate

This block sits between a bank of clock sources and the pins they drive. It stops those clocks cleanly when the power-down pin is pulled low. It can also keep individual clocks quiet through a per-output enable vector, and it can float every pin at once. The power-down pin is active low and may change at any time. The block samples it on the rising edges of a reference clock and acts only when two consecutive samples agree. Stopping and restarting happen one output at a time, each in its own clock domain. Every output therefore only ever changes while its source is low, so an output never emits a shortened high phase.

The reference-clock logic decides which outputs should run and passes that decision to one gating cell per output. Each cell captures the decision on its source's rising edge and applies it on the following falling edge. The gated clock is the AND of the source and that falling-edge flop. The run state of every cell is synchronised back into the reference domain to drive a status flag. The flag rises once power-down is in force and every output has come to rest low. One output, chosen by parameter, is free-running: it ignores its enable bit and stops only for power-down.

Top module: `clk_pd_gate`

## Requirements
- R1: While `rst_n` is low for several cycles of the reference clock and of every source, every `clk_out` bit is low and `all_stopped` is 0.
- R2: Power-down takes effect only after `pd_n` reads 0 on two consecutive rising edges of `ref_clk`. A low pulse caught by just one rising edge leaves every output running and `all_stopped` at 0.
- R3: Once power-down is in effect, every output settles low and stays low. Every high pulse that appears on an output, whether before, during or after power-down, lasts exactly one high phase of its source.
- R4: An output whose `out_en` bit is 0 (other than the free-running one) stays low, with power-down active or not. An output whose bit is 1 follows its source while power-down is not in effect.
- R5: The output at index `FREE_IDX` follows its source whatever its `out_en` bit holds, and stops only for power-down.
- R6: While `hiz` is 1, every `clk_out` bit is high impedance, whatever the enables and power-down state are. Clearing `hiz` restores normal driving.
- R7: Power-down ends only after `pd_n` reads 1 on two consecutive rising edges of `ref_clk`. Each output then resumes at a low-phase boundary, so its first high pulse is full width.
- R8: `all_stopped` is 1 only while power-down is in effect and every output has reached its stopped low state. It returns to 0 once power-down ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock that samples the power-down pin |
| rst_n | input | 1 | Synchronous active-low reset, held across edges of all clocks |
| pd_n | input | 1 | Asynchronous active-low power-down request |
| src_clk | input | N_OUT | Clock sources to be gated, one per output |
| out_en | input | N_OUT | Per-output enable; 0 holds that output low |
| hiz | input | 1 | 1 floats every output |
| clk_out | output | N_OUT | Gated clocks, or high impedance when `hiz` is 1 |
| all_stopped | output | 1 | 1 when power-down is in effect and all outputs are at rest low |

## Verification
The bench builds the block with four outputs and the free-running slot at index 3. The four sources have distinct half periods of 3, 4, 5 and 7 ns against a 10 ns reference. This small setting lets the bench step through all sixteen enable patterns and run a full power-down entry and release for each one. It also times every single high pulse on every output, so a runt caused by an edge landing in the wrong phase of any source cannot go unnoticed. A one-edge glitch on the power-down pin and a spell of high impedance with pull-ups on the nets are checked separately.

// File: rtl/clk_pd_gate_pkg.sv
`timescale 1ns/1ps
// Shared types for the clock power-down gate.
// Assumes nothing beyond a single reference-clock domain using the state type.
package clk_pd_gate_pkg;

    // Qualified power-down state seen by the reference-clock logic.
    typedef enum logic {
        PDS_RUN  = 1'b0,
        PDS_DOWN = 1'b1
    } pd_state_t;

endpackage

// File: rtl/pd_qualifier.sv
`timescale 1ns/1ps
// Samples the asynchronous power-down pin on the reference clock and reports
// a qualified power-down state. Entry needs two consecutive low samples,
// exit needs two consecutive high samples.
// Assumes: pd_n is free to change at any time; one metastability flop in front.
module pd_qualifier
    import clk_pd_gate_pkg::*;
(
    input  logic ref_clk,
    input  logic rst_n,
    input  logic pd_n,
    output logic pd_act
);

    logic      pin_meta;
    logic      samp_new;
    logic      samp_old;
    pd_state_t state;

    // Capture the pin and keep the two most recent settled samples.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            pin_meta <= 1'b1;
            samp_new <= 1'b1;
            samp_old <= 1'b1;
        end else begin
            pin_meta <= pd_n;
            samp_new <= pin_meta;
            samp_old <= samp_new;
        end
    end

    // Move between running and down only when both samples agree.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            state <= PDS_RUN;
        end else begin
            case (state)
                PDS_RUN:  if (!samp_new && !samp_old) state <= PDS_DOWN;
                PDS_DOWN: if (samp_new && samp_old)   state <= PDS_RUN;
                default:  state <= PDS_RUN;
            endcase
        end
    end

    assign pd_act = (state == PDS_DOWN);

    // R2: entry follows two consecutive low readings of the pin.
    p_pd_entry_r2: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(pd_act) |-> (!$past(pd_n, 3) && !$past(pd_n, 4)));

    // R7: exit follows two consecutive high readings of the pin.
    p_pd_exit_r7: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $fell(pd_act) |-> ($past(pd_n, 3) && $past(pd_n, 4)));

endmodule

// File: rtl/run_request.sv
`timescale 1ns/1ps
// Decides, in the reference domain, which outputs should be running.
// Power-down clears every request; otherwise the enable vector applies,
// with the free-running slot forced on.
// Assumes: out_en is quasi-static relative to ref_clk.
module run_request #(
    parameter int N_OUT    = 10,
    parameter int FREE_IDX = 9
) (
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic             pd_act,
    input  logic [N_OUT-1:0] out_en,
    output logic [N_OUT-1:0] run_req
);

    localparam logic [N_OUT-1:0] FREE_MASK = {{(N_OUT-1){1'b0}}, 1'b1} << FREE_IDX;

    // Register the per-output run decision.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            run_req <= '0;
        end else if (pd_act) begin
            run_req <= '0;
        end else begin
            run_req <= out_en | FREE_MASK;
        end
    end

    // R3: a qualified power-down withdraws every run request.
    p_req_cleared_r3: assert property (@(posedge ref_clk) disable iff (!rst_n)
        pd_act |=> (run_req == '0));

    // R5: the free-running slot is requested whenever power-down is off.
    p_free_req_r5: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !pd_act |=> run_req[FREE_IDX]);

endmodule

// File: rtl/gate_cell.sv
`timescale 1ns/1ps
// Gates one clock without a latch: the run request is captured on the
// source's rising edge and applied on its falling edge, so the AND gate's
// enable only moves while the source is low.
// Assumes: rst_n is held across at least one full source period.
module gate_cell (
    input  logic src_clk,
    input  logic rst_n,
    input  logic run_req,
    output logic gate_on,
    output logic clk_gated
);

    logic req_cap;

    // Bring the request into this source's domain during its high phase.
    always_ff @(posedge src_clk) begin
        if (!rst_n) req_cap <= 1'b0;
        else        req_cap <= run_req;
    end

    // Apply the request at the high-to-low transition only.
    always_ff @(negedge src_clk) begin
        if (!rst_n) gate_on <= 1'b0;
        else        gate_on <= req_cap;
    end

    assign clk_gated = src_clk & gate_on;

endmodule

// File: rtl/stop_monitor.sv
`timescale 1ns/1ps
// Brings each cell's run state back to the reference domain and raises a
// flag once power-down is in effect and every output has come to rest.
// Assumes: SYNC_LEN >= 2.
module stop_monitor #(
    parameter int N_OUT    = 10,
    parameter int SYNC_LEN = 2
) (
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic             pd_act,
    input  logic [N_OUT-1:0] gate_on,
    output logic             all_stopped
);

    logic [SYNC_LEN-1:0] chain [N_OUT];
    logic [N_OUT-1:0]    seen_on;

    for (genvar i = 0; i < N_OUT; i++) begin : g_back
        // Resynchronise one cell's run state.
        always_ff @(posedge ref_clk) begin
            if (!rst_n) chain[i] <= '0;
            else        chain[i] <= {chain[i][SYNC_LEN-2:0], gate_on[i]};
        end
        assign seen_on[i] = chain[i][SYNC_LEN-1];
    end

    // Report rest only while power-down holds and no cell is running.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) all_stopped <= 1'b0;
        else        all_stopped <= pd_act && (seen_on == '0);
    end

    // R8: the flag never stands without a qualified power-down behind it.
    p_status_r8: assert property (@(posedge ref_clk) disable iff (!rst_n)
        all_stopped |-> $past(pd_act));

endmodule

// File: rtl/clk_pd_gate.sv
`timescale 1ns/1ps
// Top of the clock power-down gate: qualifies the power-down pin, forms
// per-output run requests, gates each source in its own domain, reports
// rest, and floats the outputs on request.
// Assumes: hiz is a static control; sources keep running during reset.
module clk_pd_gate #(
    parameter int N_OUT    = 10,
    parameter int FREE_IDX = 9,
    parameter int SYNC_LEN = 2
) (
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic             pd_n,
    input  logic [N_OUT-1:0] src_clk,
    input  logic [N_OUT-1:0] out_en,
    input  logic             hiz,
    output logic [N_OUT-1:0] clk_out,
    output logic             all_stopped
);

    logic             pd_act;
    logic [N_OUT-1:0] run_req;
    logic [N_OUT-1:0] gate_on;
    logic [N_OUT-1:0] gated;

    pd_qualifier u_qual (
        .ref_clk (ref_clk),
        .rst_n   (rst_n),
        .pd_n    (pd_n),
        .pd_act  (pd_act)
    );

    run_request #(.N_OUT(N_OUT), .FREE_IDX(FREE_IDX)) u_req (
        .ref_clk (ref_clk),
        .rst_n   (rst_n),
        .pd_act  (pd_act),
        .out_en  (out_en),
        .run_req (run_req)
    );

    for (genvar i = 0; i < N_OUT; i++) begin : g_cell
        gate_cell u_cell (
            .src_clk   (src_clk[i]),
            .rst_n     (rst_n),
            .run_req   (run_req[i]),
            .gate_on   (gate_on[i]),
            .clk_gated (gated[i])
        );
    end

    stop_monitor #(.N_OUT(N_OUT), .SYNC_LEN(SYNC_LEN)) u_mon (
        .ref_clk     (ref_clk),
        .rst_n       (rst_n),
        .pd_act      (pd_act),
        .gate_on     (gate_on),
        .all_stopped (all_stopped)
    );

    // Float every pin when requested, otherwise drive the gated clocks.
    assign clk_out = hiz ? {N_OUT{1'bz}} : gated;

endmodule

// File: tb/sim_clk_pd_gate.sv
`timescale 1ns/1ps
module sim_clk_pd_gate;

    localparam int REF_PERIOD = 10;
    localparam int N          = 4;
    localparam int FREE       = 3;

    function automatic int half_of(input int i);
        case (i)
            0: return 3;
            1: return 4;
            2: return 5;
            default: return 7;
        endcase
    endfunction

    logic ref_clk = 1'b0;
    logic rst_n   = 1'b0;
    logic pd_n    = 1'b1;
    logic hiz     = 1'b0;
    logic [N-1:0] en = '0;
    wire  [N-1:0] src;
    wire  [N-1:0] out_w;
    logic all_stopped;

    int  vectors = 0;
    int  errors  = 0;
    bit  mon_on  = 1'b0;
    bit  done    = 1'b0;

    always #(REF_PERIOD/2) ref_clk = ~ref_clk;

    clk_pd_gate #(.N_OUT(N), .FREE_IDX(FREE)) u0 (
        .ref_clk     (ref_clk),
        .rst_n       (rst_n),
        .pd_n        (pd_n),
        .src_clk     (src),
        .out_en      (en),
        .hiz         (hiz),
        .clk_out     (out_w),
        .all_stopped (all_stopped)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Sources, pull-ups and per-output pulse-width monitors (R3, R7).
    for (genvar g = 0; g < N; g++) begin : g_src
        logic s = 1'b0;
        time  t_rise = 0;
        bit   rise_ok = 1'b0;
        always #(half_of(g)) s = ~s;
        assign src[g] = s;
        pullup pu (out_w[g]);
        always @(posedge out_w[g]) begin
            t_rise  = $time;
            rise_ok = mon_on;
        end
        always @(negedge out_w[g]) begin
            if (mon_on && rise_ok) begin
                check(($time - t_rise) == half_of(g), "R3 pulse width",
                      int'($time - t_rise), half_of(g));
            end
            rise_ok = 1'b0;
        end
    end

    // Sample outputs at half-ns offsets against the expected mask.
    task automatic window(input logic [N-1:0] run_mask, input bit pulled,
                          input string tag, input int len);
        int bad [N];
        for (int i = 0; i < N; i++) bad[i] = 0;
        @(posedge ref_clk);
        #0.5;
        for (int k = 0; k < len; k++) begin
            #1;
            for (int i = 0; i < N; i++) begin
                logic e;
                e = pulled ? 1'b1 : (run_mask[i] ? src[i] : 1'b0);
                if (out_w[i] !== e) bad[i]++;
            end
        end
        for (int i = 0; i < N; i++) check(bad[i] == 0, tag, bad[i], 0);
    endtask

    task automatic drive_pd(input logic v);
        @(posedge ref_clk);
        #1 pd_n = v;
    endtask

    initial begin
        logic [N-1:0] eff;
        // R1: reset state.
        repeat (6) @(posedge ref_clk);
        window('0, 1'b0, "R1 outputs low in reset", 20);
        check(all_stopped == 1'b0, "R1 status in reset", all_stopped, 0);
        @(posedge ref_clk);
        #1 rst_n = 1'b1;
        repeat (4) @(posedge ref_clk);
        mon_on = 1'b1;

        // Sweep every enable pattern through a power-down cycle.
        for (int p = 0; p < (1 << N); p++) begin
            @(posedge ref_clk);
            #1 en = p[N-1:0];
            eff = p[N-1:0] | (N'(1) << FREE);
            repeat (5) @(posedge ref_clk);
            window(eff, 1'b0, (p[FREE] ? "R4 enabled outputs" : "R4 R5 enables with free slot"), 60);
            check(all_stopped == 1'b0, "R8 status while running", all_stopped, 0);
            drive_pd(1'b0);
            repeat (15) @(posedge ref_clk);
            check(all_stopped == 1'b1, "R8 status after power-down", all_stopped, 1);
            window('0, 1'b0, "R3 outputs stopped low", 60);
            drive_pd(1'b1);
            repeat (15) @(posedge ref_clk);
            check(all_stopped == 1'b0, "R8 status after release", all_stopped, 0);
            window(eff, 1'b0, "R7 outputs resumed", 60);
        end

        // R2: a low pulse seen on one edge only is ignored.
        @(posedge ref_clk);
        #1 en = '1;
        repeat (5) @(posedge ref_clk);
        fork
            begin
                drive_pd(1'b0);
                drive_pd(1'b1);
            end
            window('1, 1'b0, "R2 single-sample glitch ignored", 150);
        join
        check(all_stopped == 1'b0, "R2 status after glitch", all_stopped, 0);

        // R6: all outputs float, read as pulled high.
        @(posedge ref_clk);
        #1 en = 4'b0101;
        mon_on = 1'b0;
        repeat (5) @(posedge ref_clk);
        #1 hiz = 1'b1;
        window('0, 1'b1, "R6 outputs floating", 40);
        @(posedge ref_clk);
        #1 hiz = 1'b0;
        repeat (3) @(posedge ref_clk);
        mon_on = 1'b1;
        window(4'b1101, 1'b0, "R6 driving restored", 60);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #(REF_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule